// File: doc/BRIEF.md
# Clock Output Gating Controller

This block decides, for every clock output of a clock generator, whether that output runs, is held at logic low, or floats. The outputs are three CPU pairs (two CPU plus one debug-port pair), four SRC pairs, a SATA pair, a DOT96 pair, three PCI clocks, a 48 MHz clock, a 25 MHz clock and a 14.318 MHz reference. Each output's state is a 2-bit code. The downstream output buffers consume these codes. The PLLs and the pad drivers are outside the block.

The block takes four asynchronous control pins: two active-low SRC request pins, an active-low PCI stop and an active-low CPU stop. It also takes configuration bits from the register file and the power-down state. Configuration covers per-output enables, the routing of the two request pins, the function of the shared request/PCI pin and whether SRC obeys PCI stop.

The pins pass through a synchronizer in the output clock domain. A single registered decision stage follows. A stop or restart therefore lands on a whole clock edge and never cuts a pulse short.

Top module: `clk_out_gate`

## Requirements
- R1: While reset is high, every differential output reports LOW (code 01) and every single-ended output reports HIZ (code 10).
- R2: A change on any of the four control pins shows up at the outputs on the third rising clock edge after the change, and not on any earlier edge.
- R3: When `pin10_req` is 0, the request input A is ignored, and PCI output 2 (the shared pin) follows the normal stoppable PCI rules. When `pin10_req` is 1, PCI output 2 reports HIZ and request A is active.
- R4: Request A controls SRC index 0 when `reqa_sel` is 0 and SRC index 1 when `reqa_sel` is 1.
- R5: Request B controls SRC index 2 when `reqb_sel` is 0 and SRC index 3 when `reqb_sel` is 1.
- R6: A controlled SRC output reports LOW while its request pin is high and RUN while it is low. An SRC output that no active request controls is unaffected by request pins.
- R7: While `pci_stop_n` is low, PCI outputs 1 and 2 report LOW. PCI output 0 is free-running and keeps reporting RUN.
- R8: When `src_stoppable` is 1, `pci_stop_n` low also forces all four SRC outputs LOW. When it is 0, SRC ignores `pci_stop_n`.
- R9: While `cpu_stop_n` is low, all CPU outputs report LOW. SRC, SATA, DOT96 and the single-ended outputs are unaffected.
- R10: A cleared enable bit forces its output to LOW if the output is differential, or HIZ if it is single-ended, whatever the other inputs are. This takes effect on the next rising edge.
- R11: With `pwr_down` high, differential outputs report LOW and single-ended outputs report HIZ. The exception is the 25 MHz output, which reports RUN when both `wol_en` and its enable are 1. This takes effect on the next rising edge.
- R12: The state codes are RUN = 00, LOW = 01 and HIZ = 10. Code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| reqa_n | input | 1 | Request pin A, active low, asynchronous |
| reqb_n | input | 1 | Request pin B, active low, asynchronous |
| pci_stop_n | input | 1 | PCI stop pin, active low, asynchronous |
| cpu_stop_n | input | 1 | CPU stop pin, active low, asynchronous |
| pin10_req | input | 1 | 1: shared pin is request A; 0: shared pin is PCI output 2 |
| reqa_sel | input | 1 | Request A target (0: SRC0, 1: SRC1) |
| reqb_sel | input | 1 | Request B target (0: SRC2, 1: SRC3) |
| src_stoppable | input | 1 | 1: SRC obeys PCI stop |
| pwr_down | input | 1 | Power-down state |
| wol_en | input | 1 | Keep 25 MHz running in power-down |
| cpu_oe | input | NCPU | CPU pair enables |
| src_oe | input | NSRC | SRC pair enables |
| sata_oe | input | 1 | SATA pair enable |
| dot_oe | input | 1 | DOT96 pair enable |
| pci_oe | input | NPCI | PCI clock enables (index 0 free-running) |
| usb_oe | input | 1 | 48 MHz enable |
| c25_oe | input | 1 | 25 MHz enable |
| ref_oe | input | 1 | Reference clock enable |
| cpu_st | output | 2*NCPU | CPU pair states |
| src_st | output | 2*NSRC | SRC pair states |
| sata_st | output | 2 | SATA pair state |
| dot_st | output | 2 | DOT96 pair state |
| pci_st | output | 2*NPCI | PCI clock states |
| usb_st | output | 2 | 48 MHz state |
| c25_st | output | 2 | 25 MHz state |
| ref_st | output | 2 | Reference clock state |

## Verification
The interesting collisions are a pin-driven stop coinciding with a configuration-driven override. One case is request B high while SRC3's enable is cleared, or while power-down is entered. Another is PCI stop with SRC made stoppable while request A also targets the same SRC. The bench provokes these by sweeping every combination of the four pins and six mode bits with all enables set. It then walks a single cleared enable across every output, with and without power-down. In each state it compares all outputs against an arithmetic model of the precedence order, where enable and power-down override stops and any stop source yields LOW. Separate edge-by-edge probes confirm that a pin change is invisible two edges later and visible on the third.

// File: rtl/cog_pkg.sv
package cog_pkg;

  typedef enum logic [1:0] {
    OUT_RUN = 2'b00,
    OUT_LOW = 2'b01,
    OUT_HIZ = 2'b10
  } out_state_e;

  // differential pair: anything that silences it parks both lines low
  function automatic out_state_e diff_next(input logic en, input logic pd, input logic stop);
    return (!en || pd || stop) ? OUT_LOW : OUT_RUN;
  endfunction

  // single-ended: disable/off floats, a stop parks at zero
  function automatic out_state_e se_next(input logic en, input logic off, input logic stop);
    if (!en || off) return OUT_HIZ;
    if (stop)       return OUT_LOW;
    return OUT_RUN;
  endfunction

endpackage

// File: rtl/cog_sync.sv
module cog_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cog_decide.sv
module cog_decide
  import cog_pkg::*;
#(
  parameter int NCPU = 3,
  parameter int NSRC = 4,
  parameter int NPCI = 3
) (
  input  logic              reqa_hi,
  input  logic              reqb_hi,
  input  logic              pci_halt,
  input  logic              cpu_halt,
  input  logic              pin10_req,
  input  logic              reqa_sel,
  input  logic              reqb_sel,
  input  logic              src_stoppable,
  input  logic              pwr_down,
  input  logic              wol_en,
  input  logic [NCPU-1:0]   cpu_oe,
  input  logic [NSRC-1:0]   src_oe,
  input  logic              sata_oe,
  input  logic              dot_oe,
  input  logic [NPCI-1:0]   pci_oe,
  input  logic              usb_oe,
  input  logic              c25_oe,
  input  logic              ref_oe,
  output logic [2*NCPU-1:0] cpu_nx,
  output logic [2*NSRC-1:0] src_nx,
  output logic [1:0]        sata_nx,
  output logic [1:0]        dot_nx,
  output logic [2*NPCI-1:0] pci_nx,
  output logic [1:0]        usb_nx,
  output logic [1:0]        c25_nx,
  output logic [1:0]        ref_nx
);
  localparam int A_LO    = 0;
  localparam int A_HI    = 1;
  localparam int B_LO    = 2;
  localparam int B_HI    = 3;
  localparam int PCI_MUX = NPCI - 1;

  int  tgt_a, tgt_b;
  logic src_pci_halt;

  always_comb begin
    tgt_a        = reqa_sel ? A_HI : A_LO;
    tgt_b        = reqb_sel ? B_HI : B_LO;
    src_pci_halt = src_stoppable && pci_halt;

    for (int i = 0; i < NCPU; i++)
      cpu_nx[2*i +: 2] = diff_next(cpu_oe[i], pwr_down, cpu_halt);

    for (int i = 0; i < NSRC; i++)
      src_nx[2*i +: 2] = diff_next(src_oe[i], pwr_down,
                                   src_pci_halt ||
                                   (pin10_req && reqa_hi && (i == tgt_a)) ||
                                   (reqb_hi && (i == tgt_b)));

    sata_nx = diff_next(sata_oe, pwr_down, 1'b0);
    dot_nx  = diff_next(dot_oe,  pwr_down, 1'b0);

    for (int i = 0; i < NPCI; i++)
      pci_nx[2*i +: 2] = se_next(pci_oe[i],
                                 pwr_down || ((i == PCI_MUX) && pin10_req),
                                 (i != 0) && pci_halt);

    usb_nx = se_next(usb_oe, pwr_down, 1'b0);
    ref_nx = se_next(ref_oe, pwr_down, 1'b0);
    c25_nx = se_next(c25_oe, pwr_down && !wol_en, 1'b0);
  end
endmodule

// File: rtl/cog_state_reg.sv
module cog_state_reg #(
  parameter int         N    = 1,
  parameter logic [1:0] RSTV = 2'b01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2*N-1:0] d,
  output logic [2*N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= {N{RSTV}};
    else     q <= d;
  end
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
  import cog_pkg::*;
#(
  parameter int NCPU        = 3,
  parameter int NSRC        = 4,
  parameter int NPCI        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqa_n,
  input  logic              reqb_n,
  input  logic              pci_stop_n,
  input  logic              cpu_stop_n,
  input  logic              pin10_req,
  input  logic              reqa_sel,
  input  logic              reqb_sel,
  input  logic              src_stoppable,
  input  logic              pwr_down,
  input  logic              wol_en,
  input  logic [NCPU-1:0]   cpu_oe,
  input  logic [NSRC-1:0]   src_oe,
  input  logic              sata_oe,
  input  logic              dot_oe,
  input  logic [NPCI-1:0]   pci_oe,
  input  logic              usb_oe,
  input  logic              c25_oe,
  input  logic              ref_oe,
  output logic [2*NCPU-1:0] cpu_st,
  output logic [2*NSRC-1:0] src_st,
  output logic [1:0]        sata_st,
  output logic [1:0]        dot_st,
  output logic [2*NPCI-1:0] pci_st,
  output logic [1:0]        usb_st,
  output logic [1:0]        c25_st,
  output logic [1:0]        ref_st
);
  localparam int NPIN  = 4;
  localparam int NDIFF = NCPU + NSRC + 2;
  localparam int NSE   = NPCI + 3;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic [2*NCPU-1:0] cpu_nx;
  logic [2*NSRC-1:0] src_nx;
  logic [2*NPCI-1:0] pci_nx;
  logic [1:0] sata_nx, dot_nx, usb_nx, c25_nx, ref_nx;

  assign pin_raw = {cpu_stop_n, pci_stop_n, reqb_n, reqa_n};

  cog_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
  );

  cog_decide #(.NCPU(NCPU), .NSRC(NSRC), .NPCI(NPCI)) u_decide (
    .reqa_hi      (pin_s[0]),
    .reqb_hi      (pin_s[1]),
    .pci_halt     (!pin_s[2]),
    .cpu_halt     (!pin_s[3]),
    .pin10_req    (pin10_req),
    .reqa_sel     (reqa_sel),
    .reqb_sel     (reqb_sel),
    .src_stoppable(src_stoppable),
    .pwr_down     (pwr_down),
    .wol_en       (wol_en),
    .cpu_oe       (cpu_oe),
    .src_oe       (src_oe),
    .sata_oe      (sata_oe),
    .dot_oe       (dot_oe),
    .pci_oe       (pci_oe),
    .usb_oe       (usb_oe),
    .c25_oe       (c25_oe),
    .ref_oe       (ref_oe),
    .cpu_nx       (cpu_nx),
    .src_nx       (src_nx),
    .sata_nx      (sata_nx),
    .dot_nx       (dot_nx),
    .pci_nx       (pci_nx),
    .usb_nx       (usb_nx),
    .c25_nx       (c25_nx),
    .ref_nx       (ref_nx)
  );

  // differential group resets parked low, single-ended group floats
  cog_state_reg #(.N(NDIFF), .RSTV(OUT_LOW)) u_diff_reg (
    .clk(clk), .rst(rst),
    .d({cpu_nx, src_nx, sata_nx, dot_nx}),
    .q({cpu_st, src_st, sata_st, dot_st})
  );

  cog_state_reg #(.N(NSE), .RSTV(OUT_HIZ)) u_se_reg (
    .clk(clk), .rst(rst),
    .d({pci_nx, usb_nx, c25_nx, ref_nx}),
    .q({pci_st, usb_st, c25_st, ref_st})
  );
endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk #(
  parameter int NCPU        = 3,
  parameter int NSRC        = 4,
  parameter int NPCI        = 3,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_stop_n,
  input logic              pwr_down,
  input logic              wol_en,
  input logic [NCPU-1:0]   cpu_oe,
  input logic [NSRC-1:0]   src_oe,
  input logic [NPCI-1:0]   pci_oe,
  input logic              c25_oe,
  input logic [2*NCPU-1:0] cpu_st,
  input logic [2*NSRC-1:0] src_st,
  input logic [1:0]        sata_st,
  input logic [1:0]        dot_st,
  input logic [2*NPCI-1:0] pci_st,
  input logic [1:0]        usb_st,
  input logic [1:0]        c25_st,
  input logic [1:0]        ref_st
);
  localparam int LAT  = SYNC_STAGES + 1;
  localparam int CW   = $clog2(LAT + 1);
  localparam int NTOT = NCPU + NSRC + NPCI + 5;

  logic [CW-1:0]     since_rst;
  logic [LAT-1:0]    stop_pipe;
  logic [2*NTOT-1:0] all_st;
  logic              settled;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != LAT[CW-1:0]) since_rst <= since_rst + 1'b1;
  end

  always_ff @(posedge clk) stop_pipe <= {stop_pipe[LAT-2:0], cpu_stop_n};

  assign settled = (since_rst == LAT[CW-1:0]);
  assign all_st  = {cpu_st, src_st, pci_st, sata_st, dot_st, usb_st, c25_st, ref_st};

  // R9
  cpu_stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    (settled && !stop_pipe[LAT-1]) |-> (cpu_st[1:0] == 2'b01));

  // R9
  cpu_resume_chk: assert property (@(posedge clk) disable iff (rst)
    (settled && stop_pipe[LAT-1] && $past(cpu_oe[0]) && !$past(pwr_down))
      |-> (cpu_st[1:0] == 2'b00));

  // R10
  src_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !src_oe[0] |=> (src_st[1:0] == 2'b01));

  // R11
  pd_float_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (usb_st == 2'b10 && ref_st == 2'b10));

  // R11
  wol_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && wol_en && c25_oe) |=> (c25_st == 2'b00));

  // R7
  free_pci_chk: assert property (@(posedge clk) disable iff (rst)
    (pci_oe[0] && !pwr_down) |=> (pci_st[1:0] == 2'b00));

  for (genvar g = 0; g < NTOT; g++) begin : g_code
    // R12
    no_code3_chk: assert property (@(posedge clk) disable iff (rst)
      all_st[2*g +: 2] != 2'b11);
  end
endmodule

bind clk_out_gate clk_out_gate_chk #(
  .NCPU(NCPU), .NSRC(NSRC), .NPCI(NPCI), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_clk_out_gate.sv
module tb_clk_out_gate;
  localparam int NCPU = 3;
  localparam int NSRC = 4;
  localparam int NPCI = 3;
  localparam logic [1:0] RUN = 2'b00, LOW = 2'b01, HIZ = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic reqa_n, reqb_n, pci_stop_n, cpu_stop_n;
  logic pin10_req, reqa_sel, reqb_sel, src_stoppable, pwr_down, wol_en;
  logic [14:0] oe_all;
  logic [NCPU-1:0] cpu_oe;
  logic [NSRC-1:0] src_oe;
  logic [NPCI-1:0] pci_oe;
  logic sata_oe, dot_oe, usb_oe, c25_oe, ref_oe;
  logic [2*NCPU-1:0] cpu_st;
  logic [2*NSRC-1:0] src_st;
  logic [2*NPCI-1:0] pci_st;
  logic [1:0] sata_st, dot_st, usb_st, c25_st, ref_st;

  assign cpu_oe  = oe_all[2:0];
  assign src_oe  = oe_all[6:3];
  assign sata_oe = oe_all[7];
  assign dot_oe  = oe_all[8];
  assign pci_oe  = oe_all[11:9];
  assign usb_oe  = oe_all[12];
  assign c25_oe  = oe_all[13];
  assign ref_oe  = oe_all[14];

  clk_out_gate dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // expected states, written from the requirement text
  function automatic logic [1:0] x_diff(input logic en, input logic halt);
    if (!en || pwr_down || halt) return LOW;
    return RUN;
  endfunction

  function automatic logic [1:0] x_se(input logic en, input logic off, input logic halt);
    if (!en || off) return HIZ;
    if (halt) return LOW;
    return RUN;
  endfunction

  task automatic check_all(input string req);
    for (int i = 0; i < NCPU; i++)
      chk(req, $sformatf("cpu%0d", i), cpu_st[2*i +: 2], x_diff(cpu_oe[i], !cpu_stop_n));
    for (int i = 0; i < NSRC; i++) begin
      logic by_a, by_b, by_pci;
      by_a   = pin10_req && reqa_n && (i == (reqa_sel ? 1 : 0));
      by_b   = reqb_n && (i == (reqb_sel ? 3 : 2));
      by_pci = src_stoppable && !pci_stop_n;
      chk(req, $sformatf("src%0d", i), src_st[2*i +: 2], x_diff(src_oe[i], by_a || by_b || by_pci));
    end
    chk(req, "sata", sata_st, x_diff(sata_oe, 1'b0));
    chk(req, "dot", dot_st, x_diff(dot_oe, 1'b0));
    chk(req, "pci0", pci_st[1:0], x_se(pci_oe[0], pwr_down, 1'b0));
    chk(req, "pci1", pci_st[3:2], x_se(pci_oe[1], pwr_down, !pci_stop_n));
    chk(req, "pci2", pci_st[5:4], x_se(pci_oe[2], pwr_down || pin10_req, !pci_stop_n));
    chk(req, "usb", usb_st, x_se(usb_oe, pwr_down, 1'b0));
    chk(req, "ref", ref_st, x_se(ref_oe, pwr_down, 1'b0));
    chk(req, "c25", c25_st, x_se(c25_oe, pwr_down && !wol_en, 1'b0));
  endtask

  task automatic apply(input logic [9:0] v);
    {reqa_n, reqb_n, pci_stop_n, cpu_stop_n, pin10_req,
     reqa_sel, reqb_sel, src_stoppable, pwr_down, wol_en} = v;
  endtask

  task automatic settle(input int edges);
    repeat (edges) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired before the run completed");
    summary();
  end

  initial begin
    oe_all = '1;
    apply(10'b0011_1000_00);  // pins released-ish, no pd
    settle(2);
    // R1: reset state
    for (int i = 0; i < NCPU; i++) chk("R1", "cpu rst", cpu_st[2*i +: 2], LOW);
    for (int i = 0; i < NSRC; i++) chk("R1", "src rst", src_st[2*i +: 2], LOW);
    chk("R1", "sata rst", sata_st, LOW);
    chk("R1", "dot rst", dot_st, LOW);
    for (int i = 0; i < NPCI; i++) chk("R1", "pci rst", pci_st[2*i +: 2], HIZ);
    chk("R1", "usb rst", usb_st, HIZ);
    chk("R1", "c25 rst", c25_st, HIZ);
    chk("R1", "ref rst", ref_st, HIZ);
    rst = 1'b0;

    // R3 R4 R5 R6 R7 R8 R9 R11 R12: every pin and mode combination
    for (int v = 0; v < 1024; v++) begin
      apply(v[9:0]);
      settle(3);
      check_all("R3,R4,R5,R6,R7,R8,R9,R11,R12");
    end

    // R10 R11: a single cleared enable walked over every output
    for (int pd = 0; pd < 2; pd++) begin
      for (int b = 0; b < 15; b++) begin
        apply({4'b0011, 1'b1, 1'b0, 1'b1, 1'b1, pd[0], 1'b1});
        oe_all = ~(15'd1 << b);
        settle(3);
        check_all("R10,R11");
        oe_all = '1;
        settle(1);
        check_all("R10");
      end
    end

    // R2: pin latency on the CPU stop
    apply(10'b0011_1000_00);
    oe_all = '1;
    settle(3);
    cpu_stop_n = 1'b0;
    settle(2);
    chk("R2", "cpu0 before 3rd edge", cpu_st[1:0], RUN);
    settle(1);
    chk("R2", "cpu0 at 3rd edge", cpu_st[1:0], LOW);
    cpu_stop_n = 1'b1;
    settle(2);
    chk("R2", "cpu0 held before 3rd edge", cpu_st[1:0], LOW);
    settle(1);
    chk("R2", "cpu0 restart at 3rd edge", cpu_st[1:0], RUN);

    // R2 R5: request B latency on SRC2
    reqb_n = 1'b1;
    settle(2);
    chk("R2", "src2 before 3rd edge", src_st[5:4], RUN);
    settle(1);
    chk("R5", "src2 stopped by req B", src_st[5:4], LOW);
    chk("R5", "src3 untouched by req B", src_st[7:6], RUN);

    // R10: enable acts on the very next edge, beating power-down keep-alive
    pwr_down = 1'b1;
    wol_en   = 1'b1;
    oe_all[13] = 1'b0;
    settle(1);
    chk("R10", "c25 disabled in pd+wol", c25_st, HIZ);
    oe_all[13] = 1'b1;
    settle(1);
    chk("R11", "c25 kept by wol", c25_st, RUN);

    summary();
  end
endmodule